// File: doc/BRIEF.md
# SDRAM refresh and self-refresh sequencer

This block keeps an SDRAM array alive without any help from the host processor. It runs its own refresh timer and issues auto-refresh commands on the SDRAM command pins at a fixed spacing. Because of this, memory contents survive while the host sits in reset or has handed the shared bus to another master.

When the system wants to go quiet, a sleep request moves the SDRAM into self-refresh. The block uses the refresh command with the clock enable pulled low and then keeps the clock enable low. A wake request brings it back out. The block first honours a minimum self-refresh residency, then waits for the clock to be reported stable, then holds a window of NOP commands. It ends the exit with an immediate auto-refresh, so the periodic timer restarts from a known point.

Timing figures are parameters counted in clock cycles. The refresh spacing is derived from the clock frequency and the refresh period in nanoseconds, and it is rounded down.

Top module: `sdram_refresh_seq`

## Requirements
- R1: During and right after reset the block drives CKE high and a NOP command (cs_n=0, ras_n=1, cas_n=1, we_n=1), with busy low and ready high.
- R2: In normal operation an auto-refresh is driven as cs_n=0, ras_n=0, cas_n=0, we_n=1 with CKE high. Consecutive auto-refreshes are exactly REF_CYC = floor(CLK_MHZ*REF_NS/1000) cycles apart, and the first one comes no later than REF_CYC cycles after reset release.
- R3: After each auto-refresh command the block drives only NOP commands for T_RC cycles in total, counting the command cycle. Ready is low for all of those cycles.
- R4: A sleep request sampled high while idle, with no refresh in progress or due, gives the self-refresh entry command (the auto-refresh encoding with CKE low) in the next cycle. A sleep request that arrives during a refresh is held, and the entry comes T_RC+1 cycles after that refresh command.
- R5: While CKE is low, the only command driven other than deselect (cs_n=1) is the entry command in its own cycle.
- R6: CKE stays low for at least T_RAS cycles after the entry command, and for as long as no wake request has been seen. A wake request that arrives before the residency is over is remembered. If the clock is already stable, CKE rises exactly T_RAS+2 cycles after the entry command.
- R7: Once the residency is over and a wake is pending, CKE stays low while clk_stable is low. CKE rises in the cycle after clk_stable is sampled high.
- R8: From the cycle CKE rises, only NOP commands are driven for XSR = max(T_XSR,2) cycles. The resume auto-refresh is driven exactly XSR cycles after the rise.
- R9: The next auto-refresh after the resume auto-refresh comes exactly REF_CYC cycles later.
- R10: Busy is high from the entry command until T_RC cycles after the resume auto-refresh, and it drops in that cycle. Busy and ready are never high together.
- R11: A wake request during normal operation has no effect. CKE stays high, busy stays low, and refresh spacing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also driven to the SDRAM |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Level request to enter self-refresh |
| wake_req | input | 1 | Request to leave self-refresh; may be a single-cycle pulse |
| clk_stable | input | 1 | High when the SDRAM clock is within its limits |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | SDRAM row strobe, active low |
| cas_n | output | 1 | SDRAM column strobe, active low |
| we_n | output | 1 | SDRAM write enable, active low |
| busy | output | 1 | High during a sleep/wake sequence, up to the end of the resume refresh |
| ready | output | 1 | High in normal operation when no refresh command or recovery is under way |

## Verification
The outputs decode straight from registered state, so each result shows up in the cycle after the edge that samples its cause:
- A sleep request turns into the entry command one cycle later.
- A clk_stable rise turns into a CKE rise one cycle later.
- The resume refresh follows the CKE rise by XSR cycles.
- Periodic refreshes follow one another by REF_CYC cycles.

The scoreboard stores each expected command event together with its distance in cycles from the previous event. The monitor samples every falling edge and compares both the kind of event and the measured gap. Status checks advance a counted number of falling edges from an observed event, so each one lands on the cycle the requirement predicts.

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq #(
  parameter int CLK_MHZ = 200,
  parameter int REF_NS  = 15625,
  parameter int T_RAS   = 9,
  parameter int T_XSR   = 14,
  parameter int T_RC    = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic clk_stable,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic busy,
  output logic ready
);
  localparam int REF_CYC = CLK_MHZ * REF_NS / 1000;
  localparam int XSR     = (T_XSR < 2) ? 2 : T_XSR;
  localparam int TW      = $clog2(REF_CYC + 1);
  localparam int MX1     = (T_RAS > XSR) ? T_RAS : XSR;
  localparam int MXC     = (MX1 > T_RC) ? MX1 : T_RC;
  localparam int CW      = $clog2(MXC + 1) + 1;
  localparam int RW      = $clog2(T_RC + 1);

  typedef enum logic [2:0] {
    IDLE_REFRESHING, ENTER_SR, IN_SR, WAIT_CLK_STABLE, EXIT_NOP, RESUME
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [RW-1:0] rc;
  logic [CW-1:0] cnt;
  logic          wake_l;

  logic due, ref_issue, sre_cmd, sr_low;

  assign due       = (st == IDLE_REFRESHING) && (rc == '0) && (tmr == TW'(REF_CYC - 1));
  assign ref_issue = due || ((st == RESUME) && (cnt == '0));
  assign sre_cmd   = (st == ENTER_SR);
  assign sr_low    = st inside {ENTER_SR, IN_SR, WAIT_CLK_STABLE};

  assign cke   = !sr_low;
  assign cs_n  = st inside {IN_SR, WAIT_CLK_STABLE};
  assign ras_n = !(ref_issue || sre_cmd);
  assign cas_n = !(ref_issue || sre_cmd);
  assign we_n  = 1'b1;
  assign busy  = (st != IDLE_REFRESHING);
  assign ready = (st == IDLE_REFRESHING) && (rc == '0) && !due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE_REFRESHING;
      tmr    <= '0;
      rc     <= '0;
      cnt    <= '0;
      wake_l <= 1'b0;
    end else begin
      if (ref_issue)                       tmr <= '0;
      else if (tmr != TW'(REF_CYC - 1))    tmr <= tmr + 1'b1;

      unique case (st)
        IDLE_REFRESHING: begin
          if (rc != '0)       rc <= rc - 1'b1;
          else if (due)       rc <= RW'(T_RC - 1);
          else if (sleep_req) st <= ENTER_SR;
        end
        ENTER_SR: begin
          cnt    <= '0;
          wake_l <= wake_req;
          st     <= IN_SR;
        end
        IN_SR: begin
          if (wake_req) wake_l <= 1'b1;
          if (cnt != CW'(T_RAS - 1)) cnt <= cnt + 1'b1;
          else if (wake_req || wake_l) begin
            wake_l <= 1'b0;
            st     <= WAIT_CLK_STABLE;
          end
        end
        WAIT_CLK_STABLE: begin
          if (clk_stable) begin
            cnt <= '0;
            st  <= EXIT_NOP;
          end
        end
        EXIT_NOP: begin
          if (cnt == CW'(XSR - 1)) begin
            cnt <= '0;
            st  <= RESUME;
          end else cnt <= cnt + 1'b1;
        end
        RESUME: begin
          if (cnt == CW'(T_RC - 1)) st <= IDLE_REFRESHING;
          else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE_REFRESHING;
      endcase
    end
  end
endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk #(
  parameter int CLK_MHZ = 200,
  parameter int REF_NS  = 15625,
  parameter int T_RAS   = 9,
  parameter int T_XSR   = 14,
  parameter int T_RC    = 14
) (
  input logic clk,
  input logic rst_n,
  input logic clk_stable,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic busy,
  input logic ready
);
  localparam int REF_CYC = CLK_MHZ * REF_NS / 1000;

  logic is_ref, is_nop;
  int   gap_cnt, sr_cnt;

  assign is_ref = !cs_n && !ras_n && !cas_n && we_n;
  assign is_nop = !cs_n && ras_n && cas_n && we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= 0;
      sr_cnt  <= 0;
    end else begin
      if ((is_ref && cke) || !cke) gap_cnt <= 0;
      else if (gap_cnt <= REF_CYC) gap_cnt <= gap_cnt + 1;
      if (is_ref && !cke)          sr_cnt <= 0;
      else if (sr_cnt <= T_RAS)    sr_cnt <= sr_cnt + 1;
    end
  end

  a_r2_refresh_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> gap_cnt <= REF_CYC);
  a_r5_sr_inputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cs_n || is_ref));
  a_r6_min_residency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> sr_cnt >= T_RAS);
  a_r7_stable_before_cke: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable));
  a_r8_nop_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> is_nop);
  a_r8_nop_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |=> is_nop);
  a_r10_busy_excludes_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready);
  a_r10_busy_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> busy);
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .REF_NS(REF_NS), .T_RAS(T_RAS), .T_XSR(T_XSR), .T_RC(T_RC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .cke(cke), .cs_n(cs_n),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .busy(busy), .ready(ready)
);

// File: tb/sim_sdram_refresh_seq.sv
`timescale 1ns/1ps
module sim_sdram_refresh_seq;
  localparam int CLK_MHZ = 200;
  localparam int REF_NS  = 500;
  localparam int T_RAS   = 8;
  localparam int T_XSR   = 1;
  localparam int T_RC    = 3;
  localparam int REF_CYC = CLK_MHZ * REF_NS / 1000;
  localparam int XSR     = (T_XSR < 2) ? 2 : T_XSR;
  localparam int K_AREF = 1, K_SRE = 2, K_UP = 3;

  logic clk = 0, rst_n = 0, sleep_req = 0, wake_req = 0, clk_stable = 1;
  logic cke, cs_n, ras_n, cas_n, we_n, busy, ready;

  sdram_refresh_seq #(.CLK_MHZ(CLK_MHZ), .REF_NS(REF_NS), .T_RAS(T_RAS),
                      .T_XSR(T_XSR), .T_RC(T_RC)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .clk_stable(clk_stable), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .busy(busy), .ready(ready));

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0;
  int cyc = 0, last_cyc = 0, ev_cnt = 0, first_ev_cyc = 0, nop_win = 0;
  logic cke_prev = 1;
  bit done = 0;
  int    exp_kind[$];
  int    exp_gap[$];
  string exp_tag[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push_exp(int kind, int gap, string tag);
    exp_kind.push_back(kind);
    exp_gap.push_back(gap);
    exp_tag.push_back(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      int kind;
      bit is_ref;
      is_ref = !cs_n && !ras_n && !cas_n && we_n;
      kind = 0;
      if (is_ref && cke)  kind = K_AREF;
      if (is_ref && !cke) kind = K_SRE;
      if (cke && !cke_prev) begin
        kind = K_UP;
        nop_win = XSR;
      end
      if (nop_win > 0) begin
        chk(!cs_n && ras_n && cas_n && we_n, "R8", "NOP in exit window", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        nop_win--;
      end
      if (kind != 0) begin
        if (exp_kind.size() == 0) begin
          chk(0, "R2", "unexpected command event", kind, 0);
        end else begin
          int ek, eg;
          string et;
          ek = exp_kind.pop_front();
          eg = exp_gap.pop_front();
          et = exp_tag.pop_front();
          chk(kind == ek, et, "event kind", kind, ek);
          if (eg >= 0) chk(cyc - last_cyc == eg, et, "event gap", cyc - last_cyc, eg);
        end
        if (ev_cnt == 0) first_ev_cyc = cyc;
        last_cyc = cyc;
        ev_cnt++;
      end
      cke_prev = cke;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R2", "watchdog expired", ev_cnt, 12);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cke == 1, "R1", "cke in reset", cke, 1);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "NOP in reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(busy == 0, "R1", "busy in reset", busy, 0);
    chk(ready == 1, "R1", "ready in reset", ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(cke == 1 && busy == 0, "R1", "cke/busy after release", {cke, busy}, 2'b10);

    push_exp(K_AREF, -1, "R2");
    push_exp(K_AREF, REF_CYC, "R2");
    push_exp(K_AREF, REF_CYC, "R2");
    wait (ev_cnt == 1);
    chk(first_ev_cyc <= REF_CYC, "R2", "first refresh cycle", first_ev_cyc, REF_CYC);
    chk(ready == 0, "R3", "ready on refresh cycle", ready, 0);
    repeat (T_RC - 1) @(negedge clk);
    chk(ready == 0, "R3", "ready at end of recovery", ready, 0);
    @(negedge clk);
    chk(ready == 1, "R3", "ready after recovery", ready, 1);
    wait (ev_cnt == 3);

    push_exp(K_AREF, REF_CYC, "R11");
    repeat (10) @(negedge clk);
    wake_req = 1;
    @(negedge clk);
    wake_req = 0;
    chk(cke == 1, "R11", "cke after idle wake", cke, 1);
    chk(busy == 0, "R11", "busy after idle wake", busy, 0);
    wait (ev_cnt == 4);

    push_exp(K_SRE, T_RC + 1, "R4");
    push_exp(K_UP, T_RAS + 2, "R6");
    push_exp(K_AREF, XSR, "R8");
    push_exp(K_AREF, REF_CYC, "R9");
    sleep_req = 1;
    wait (ev_cnt == 5);
    sleep_req = 0;
    wake_req = 1;
    chk(busy == 1 && ready == 0, "R10", "busy/ready at entry", {busy, ready}, 2'b10);
    @(negedge clk);
    wake_req = 0;
    repeat (3) @(negedge clk);
    chk(cke == 0, "R5", "cke held low", cke, 0);
    chk(cs_n == 1, "R5", "deselect in self-refresh", cs_n, 1);
    wait (ev_cnt == 7);
    chk(busy == 1, "R10", "busy on resume refresh", busy, 1);
    repeat (T_RC - 1) @(negedge clk);
    chk(busy == 1, "R10", "busy at end of resume", busy, 1);
    @(negedge clk);
    chk(busy == 0 && ready == 1, "R10", "busy/ready after resume", {busy, ready}, 2'b01);
    wait (ev_cnt == 8);

    push_exp(K_SRE, 21, "R4");
    push_exp(K_UP, -1, "R7");
    push_exp(K_AREF, XSR, "R8");
    push_exp(K_AREF, REF_CYC, "R9");
    clk_stable = 0;
    repeat (20) @(negedge clk);
    sleep_req = 1;
    wait (ev_cnt == 9);
    sleep_req = 0;
    repeat (30) @(negedge clk);
    chk(cke == 0, "R6", "cke low without wake", cke, 0);
    wake_req = 1;
    @(negedge clk);
    wake_req = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(cke == 0, "R7", "cke low while clock unstable", cke, 0);
    end
    clk_stable = 1;
    chk(cke == 0, "R7", "cke before stable sampled", cke, 0);
    @(negedge clk);
    chk(cke == 1, "R7", "cke after stable sampled", cke, 1);
    wait (ev_cnt == 12);
    repeat (5) @(negedge clk);
    chk(exp_kind.size() == 0, "R9", "pending expected events", exp_kind.size(), 0);
    finish_run();
  end
endmodule